// File: doc/BRIEF.md
# Daisy-Chainable Quad 8-Bit DAC Serial Front End

This block is the digital interface of a four-channel 8-bit digital-to-analog converter. A host writes 12-bit command words over a three-wire serial link: a clock (`sclk`), an active-low select (`csN`) and data (`din`). Each word carries a 2-bit channel address, a 2-bit control code and an 8-bit code value, sent most significant bit first. The word is acted on when `csN` rises. Every channel has an input register and a DAC register. The DAC register values, which feed the analog converters, are brought out on `dacCode`.

The internal shift register also drives the serial output `dout`, so several devices can be chained with one device's `dout` wired to the next device's `din`. A no-operation word lets data pass through a device without changing its state. The edge on which `dout` changes is selectable by command. Two asynchronous level pins complete the interface. `ldacN` held low makes the DAC registers follow the input registers. `clrN` held low zeroes every input and DAC register. `sclk`, `csN` and `din` are oversampled by the system clock `clk` through two-flop synchronizers, so events act about three `clk` cycles after the pin changes.

Top module: `qdac_serial_front`

## Requirements
- R1: After reset, every 8-bit field of `dacCode` is 0, `dout` is 0, and `dout` uses rising-edge timing.
- R2: While `csN` is low, each rising `sclk` edge shifts `din` into a 12-bit register. The first bit sent is address bit 1, then address bit 0, then control bit 1, then control bit 0, then the code from bit 7 down to bit 0. On the rising edge of `csN`, only the last 12 bits received are decoded.
- R3: Control code 01 writes the code to the addressed input register only. While `ldacN` is high, no DAC output changes.
- R4: Control code 11 writes the code to the addressed input register and to that channel's DAC register.
- R5: Control code 10 writes the code to the addressed input register and then copies all four input registers into their DAC registers.
- R6: Control code 00 selects a special command by address. Address 00 is a no-operation that changes no register. Address 01 copies all input registers to the DAC registers. Address 10 selects falling-edge `dout` and also copies all input registers to the DAC registers. Address 11 selects rising-edge `dout`.
- R7: With rising-edge timing, `dout` changes on rising `sclk` edges and shows the bit that entered 12 `sclk` periods earlier. With falling-edge timing, `dout` changes on falling `sclk` edges with a lag of 12.5 periods. The timing selection changes only through an R6 command or reset.
- R8: While `csN` is high, `sclk` activity neither shifts the register nor changes `dout`.
- R9: While `ldacN` is low, each `dacCode` field follows its input register. When `ldacN` rises, the DAC registers keep the last value they followed.
- R10: `clrN` low zeroes all input and DAC registers at once, asynchronously. It leaves the `dout` timing selection unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, idles low |
| csN | input | 1 | Active-low frame select; its rising edge executes the word |
| din | input | 1 | Serial data in |
| ldacN | input | 1 | Active-low level that makes the DAC registers transparent |
| clrN | input | 1 | Active-low asynchronous clear of input and DAC registers |
| dout | output | 1 | Serial data out, for daisy chains |
| dacCode | output | 32 | DAC register values; channel n occupies bits 8n+7 down to 8n |

## Verification
The hardest case to reach is the half-cycle difference between the two `dout` timings. It is visible only if `dout` is sampled between a rising and the following falling `sclk` edge, after a mode command has run, and with enough history shifted in that stale and fresh bits differ. The bench samples `dout` after every single `sclk` edge. It compares `dout` against a record of every bit sent, then switches timing mode in the middle of the run and keeps sending random frames. Frames longer than 12 bits, `sclk` toggling with `csN` high, and `ldacN`/`clrN` changes between frames check that decoding and state survive these events.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int NUM_CH = 4;
  localparam int CODE_W = 8;
  localparam int ADDR_W = $clog2(NUM_CH);
  localparam int CTL_W  = 2;
  localparam int WORD_W = ADDR_W + CTL_W + CODE_W;
  localparam int HEAD_W = ADDR_W + CTL_W;

  typedef enum logic [CTL_W-1:0] {
    CTL_SPECIAL     = 2'b00,
    CTL_LOAD_IN     = 2'b01,
    CTL_LOAD_IN_ALL = 2'b10,
    CTL_LOAD_BOTH   = 2'b11
  } ctl_e;

  // address codes used when the control code is CTL_SPECIAL
  localparam logic [ADDR_W-1:0] SPC_NOP       = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] SPC_LOAD_ALL  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SPC_MODE_FALL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] SPC_MODE_RISE = ADDR_W'(3);

  typedef struct packed {
    logic shiftRise;
    logic shiftFall;
    logic wrIn;
    logic wrDacOne;
    logic loadAll;
  } strobe_t;
endpackage

// File: rtl/qdac_ctrl.sv
module qdac_ctrl
  import qdac_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              din,
  input  logic [HEAD_W-1:0] cmdHead,
  output strobe_t           stb,
  output logic              dinBit,
  output logic              csIdle,
  output logic              modeFall
);
  localparam int SYNC_D = 3;

  logic [SYNC_D-1:0] sclkPipe, csPipe;
  logic [1:0]        dinPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      dinPipe  <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_D-2:0], sclk};
      csPipe   <= {csPipe[SYNC_D-2:0], csN};
      dinPipe  <= {dinPipe[0], din};
    end
  end

  logic sclkRise, sclkFall, csRise, csLow;
  assign sclkRise = sclkPipe[1] & ~sclkPipe[2];
  assign sclkFall = ~sclkPipe[1] & sclkPipe[2];
  assign csRise   = csPipe[1] & ~csPipe[2];
  assign csLow    = ~csPipe[1];
  assign csIdle   = csPipe[1];
  assign dinBit   = dinPipe[1];

  logic [ADDR_W-1:0] addr;
  ctl_e              ctl;
  assign addr = cmdHead[HEAD_W-1 -: ADDR_W];
  assign ctl  = ctl_e'(cmdHead[CTL_W-1:0]);

  always_comb begin
    stb           = '0;
    stb.shiftRise = sclkRise & csLow;
    stb.shiftFall = sclkFall & csLow;
    if (csRise) begin
      unique case (ctl)
        CTL_LOAD_IN:     stb.wrIn = 1'b1;
        CTL_LOAD_IN_ALL: begin stb.wrIn = 1'b1; stb.loadAll = 1'b1; end
        CTL_LOAD_BOTH:   begin stb.wrIn = 1'b1; stb.wrDacOne = 1'b1; end
        default:         stb.loadAll = (addr == SPC_LOAD_ALL) || (addr == SPC_MODE_FALL);
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeFall <= 1'b0;
    end else if (csRise && ctl == CTL_SPECIAL) begin
      if (addr == SPC_MODE_FALL)      modeFall <= 1'b1;
      else if (addr == SPC_MODE_RISE) modeFall <= 1'b0;
    end
  end

  // R7: the dout timing selection only moves right after a frame ends
  assert_mode_on_frame_R7: assert property (@(posedge clk) disable iff (!rstN)
    (modeFall != $past(modeFall)) |-> $past(csRise));
endmodule

// File: rtl/qdac_datapath.sv
module qdac_datapath
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clrN,
  input  logic                     ldacN,
  input  strobe_t                  stb,
  input  logic                     dinBit,
  input  logic                     csIdle,
  input  logic                     modeFall,
  output logic [HEAD_W-1:0]        cmdHead,
  output logic                     dout,
  output logic [NUM_CH*CODE_W-1:0] dacCode
);
  logic [WORD_W-1:0] shiftReg;
  logic tailBit, fallBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      tailBit  <= 1'b0;
      fallBit  <= 1'b0;
    end else begin
      if (stb.shiftRise) begin
        shiftReg <= {shiftReg[WORD_W-2:0], dinBit};
        tailBit  <= shiftReg[WORD_W-1];
      end
      if (stb.shiftFall) fallBit <= tailBit;
    end
  end

  assign dout    = modeFall ? fallBit : tailBit;
  assign cmdHead = shiftReg[WORD_W-1 -: HEAD_W];

  logic [ADDR_W-1:0] addr;
  logic [CODE_W-1:0] code;
  assign addr = shiftReg[WORD_W-1 -: ADDR_W];
  assign code = shiftReg[CODE_W-1:0];

  logic arstN;
  assign arstN = rstN & clrN;

  logic [NUM_CH*CODE_W-1:0] inFlat, dacFlat;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [CODE_W-1:0] inQ, dacQ;
    logic hit;
    assign hit = stb.wrIn && (addr == ADDR_W'(ch));

    always_ff @(posedge clk or negedge arstN) begin
      if (!arstN) begin
        inQ  <= '0;
        dacQ <= '0;
      end else begin
        if (hit) inQ <= code;
        if (stb.loadAll || (stb.wrDacOne && hit)) dacQ <= hit ? code : inQ;
        else if (!ldacN)                         dacQ <= inQ;
      end
    end

    assign inFlat[ch*CODE_W +: CODE_W]  = inQ;
    assign dacFlat[ch*CODE_W +: CODE_W] = dacQ;
    assign dacCode[ch*CODE_W +: CODE_W] = ldacN ? dacQ : inQ;
  end

  assert_shift_lsb_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.shiftRise |=> (shiftReg[0] == $past(dinBit)));

  assert_dout_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csIdle && $past(csIdle)) |=> $stable(dout));

  assert_in_only_R3: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    (stb.wrIn && !stb.wrDacOne && !stb.loadAll && ldacN) |=> $stable(dacFlat));

  assert_nop_keeps_R6: assert property (@(posedge clk) disable iff (!rstN || !clrN)
    !stb.wrIn |=> $stable(inFlat));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    !clrN |-> (inFlat == '0 && dacFlat == '0));
endmodule

// File: rtl/qdac_serial_front.sv
module qdac_serial_front
  import qdac_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     csN,
  input  logic                     din,
  input  logic                     ldacN,
  input  logic                     clrN,
  output logic                     dout,
  output logic [NUM_CH*CODE_W-1:0] dacCode
);
  strobe_t           stb;
  logic              dinBit, csIdle, modeFall;
  logic [HEAD_W-1:0] cmdHead;

  qdac_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .cmdHead(cmdHead), .stb(stb), .dinBit(dinBit), .csIdle(csIdle),
    .modeFall(modeFall)
  );

  qdac_datapath u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .ldacN(ldacN), .stb(stb),
    .dinBit(dinBit), .csIdle(csIdle), .modeFall(modeFall),
    .cmdHead(cmdHead), .dout(dout), .dacCode(dacCode)
  );
endmodule

// File: tb/tb_qdac_serial_front.sv
module tb_qdac_serial_front;
  logic clk = 1'b0, rstN = 1'b0, sclk = 1'b0, csN = 1'b1, din = 1'b0;
  logic ldacN = 1'b1, clrN = 1'b1;
  logic dout;
  logic [31:0] dacCode;

  qdac_serial_front dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .din(din),
    .ldacN(ldacN), .clrN(clrN), .dout(dout), .dacCode(dacCode)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0] refIn [4];
  logic [7:0] refDac [4];
  logic refModeFall = 1'b0;
  logic [13:0] hist = '0;

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expDac();
    logic [31:0] v;
    for (int ch = 0; ch < 4; ch++) v[ch*8 +: 8] = ldacN ? refDac[ch] : refIn[ch];
    return v;
  endfunction

  task automatic clockBit(input logic b);
    din = b;
    wclk(2);
    sclk = 1'b1;
    wclk(6);
    hist = {hist[12:0], b};
    chk("R7 dout after rise", {31'd0, dout}, {31'd0, refModeFall ? hist[13] : hist[12]});
    sclk = 1'b0;
    wclk(6);
    chk("R7 dout after fall", {31'd0, dout}, {31'd0, hist[12]});
  endtask

  task automatic applyRef(input logic [11:0] w);
    logic [1:0] a, c;
    logic [7:0] d;
    a = w[11:10]; c = w[9:8]; d = w[7:0];
    case (c)
      2'b01: refIn[a] = d;
      2'b10: begin refIn[a] = d; for (int k = 0; k < 4; k++) refDac[k] = refIn[k]; end
      2'b11: begin refIn[a] = d; refDac[a] = d; end
      default: begin
        if (a == 2'd1 || a == 2'd2) for (int k = 0; k < 4; k++) refDac[k] = refIn[k];
        if (a == 2'd2) refModeFall = 1'b1;
        if (a == 2'd3) refModeFall = 1'b0;
      end
    endcase
    if (!ldacN) for (int k = 0; k < 4; k++) refDac[k] = refIn[k];
  endtask

  task automatic sendFrame(input logic [15:0] bits, input int n, input string req);
    csN = 1'b0;
    wclk(4);
    for (int i = n - 1; i >= 0; i--) clockBit(bits[i]);
    csN = 1'b1;
    wclk(6);
    applyRef(hist[11:0]);
    chk(req, dacCode, expDac());
    chk("R8 dout after frame", {31'd0, dout}, {31'd0, hist[12]});
  endtask

  task automatic setLdac(input logic v);
    ldacN = v;
    for (int k = 0; k < 4; k++) refDac[k] = refIn[k];
    wclk(4);
    chk("R9 ldac level change", dacCode, expDac());
  endtask

  task automatic pulseClr();
    clrN = 1'b0;
    wclk(4);
    for (int k = 0; k < 4; k++) begin refIn[k] = '0; refDac[k] = '0; end
    chk("R10 clear", dacCode, 32'd0);
    clrN = 1'b1;
    wclk(3);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int k = 0; k < 4; k++) begin refIn[k] = '0; refDac[k] = '0; end
    wclk(3);
    rstN = 1'b1;
    wclk(3);
    chk("R1 reset dac", dacCode, 32'd0);
    chk("R1 reset dout", {31'd0, dout}, 32'd0);

    sendFrame(16'h1A5 | 16'h800, 12, "R3 input-only write");  // ch2, ctl 01
    sendFrame(16'h73C, 12, "R4 write input and dac");         // ch1, ctl 11
    sendFrame(16'h211, 12, "R5 write then load all");         // ch0, ctl 10
    sendFrame(16'hD77, 12, "R3 input-only write ch3");        // ch3, ctl 01
    sendFrame(16'h0FF, 12, "R6 nop");                         // addr 00 ctl 00
    sendFrame(16'h400, 12, "R6 load all");                    // addr 01 ctl 00
    sendFrame(16'h1C9, 12, "R3 write ch0");
    sendFrame(16'h800, 12, "R6 falling mode plus load all");  // addr 10 ctl 00
    // 15-bit frame: three junk bits lead, the last 12 bits write ch3 with 0x5E via ctl 11
    sendFrame(16'h6F5E | 16'h8000, 15, "R2 last twelve bits decoded");

    // sclk with csN high is ignored
    for (int i = 0; i < 3; i++) begin
      din = i[0]; wclk(2); sclk = 1'b1; wclk(6); sclk = 1'b0; wclk(6);
    end
    chk("R8 dout held while idle", {31'd0, dout}, {31'd0, hist[12]});
    sendFrame(16'h000, 12, "R8 nop after idle clocks");

    setLdac(1'b0);
    sendFrame(16'h9AB, 12, "R9 transparent write");           // ch2, ctl 01
    setLdac(1'b1);
    sendFrame(16'h933, 12, "R9 held after release");
    pulseClr();
    sendFrame(16'h000, 12, "R10 mode survives clear");
    sendFrame(16'hC00, 12, "R6 rising mode");                 // addr 11 ctl 00

    for (int f = 0; f < 70; f++) begin
      if ($urandom % 5 == 0) setLdac(~ldacN);
      if ($urandom % 15 == 0) pulseClr();
      sendFrame(16'($urandom % 4096), 12, "R2 random frame");
    end
    if (!ldacN) setLdac(1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule